// File: doc/BRIEF.md
# Programmable Watchdog With Reset Steering

This block is a byte-programmed watchdog timer. One control byte sets a countdown length and picks what happens when the countdown runs out. The countdown advances only on cycles where an external enable, pulsing once every sixteenth of a second, is high. Software keeps the watchdog from expiring in one of two ways. It can write the control byte again, or it can read it back, which restarts the countdown from the value already held.

When the countdown runs out, a flag is set in a read-only flags byte. A steering bit in the control byte then chooses one of two actions. The first is a one-cycle reset request for an external reset controller. This action also wipes the control byte and the century bit of a neighbouring date register. The second is a one-cycle interrupt pulse. The countdown is one-shot: after it runs out it stays idle until the next reload.

Top module: `wdg_steer`

## Requirements
- R1: After reset the control byte, the watchdog flag and the century bit read as 0, and both `wdg_rst_req_o` and `wdg_irq_o` are low.
- R2: A write to the control address (0x1FF7) stores the full byte. Bits [1:0] are the resolution code, bits [6:2] the multiplier and bit 7 the steering bit. A read of that address returns the stored byte.
- R3: After a load, expiry happens on the Nth tick, where N = multiplier × 4^resolution. Fewer ticks produce no pulse.
- R4: A control write clears the watchdog flag and restarts the countdown from the written value.
- R5: A read of the control address restarts the countdown from the currently stored byte.
- R6: Expiry sets bit 7 of the flags byte (address 0x1FF0). The other bits of that byte read 0.
- R7: With the steering bit at 1, expiry raises `wdg_rst_req_o` for exactly one cycle and no interrupt. It also clears the control byte to 0x00 and clears the century bit.
- R8: With the steering bit at 0, expiry raises `wdg_irq_o` for exactly one cycle and no reset request. The control byte and the century bit are left unchanged.
- R9: A multiplier of zero disables the watchdog: no number of ticks produces an expiry.
- R10: After an expiry no further expiry occurs until the countdown is reloaded.
- R11: Writes to the flags address are ignored.
- R12: Only bit 6 of the date register (address 0x1FFC) is held. A write stores bit 6, and a read returns that bit with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable per sixteenth of a second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register (0 when not reading) |
| wdg_rst_req_o | output | 1 | One-cycle reset request on steered expiry |
| wdg_irq_o | output | 1 | One-cycle interrupt pulse on unsteered expiry |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the clock edge. They also assume that a reload and a tick arriving in the same cycle resolve in favour of the reload, so a pulse always coincides with a set flag. The stimulus therefore keeps ticks and register accesses in separate cycles, with one idle cycle after each tick burst. Counts of observed pulses are compared only after that settling cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // default field widths of the control byte
   localparam int WDG_RES_W_DEF  = 2;
   localparam int WDG_MULT_W_DEF = 5;

   // what an expiry does this cycle
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_IRQ  = 2'd1,
      ACT_RST  = 2'd2
   } wdg_act_e;
endpackage

// File: rtl/wdg_interval.sv
module wdg_interval #(
   parameter int RES_W  = 2,
   parameter int MULT_W = 5,
   localparam int RES_CODES = 2 ** RES_W,
   localparam int CNT_W = MULT_W + 2 * (RES_CODES - 1)
) (
   input  logic [RES_W-1:0]  res_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic [CNT_W-1:0]  ticks_o
);
   if (RES_W < 1 || RES_W > 3) begin : g_bad_res
      $error("wdg_interval: RES_W out of range");
   end
   if (MULT_W < 1) begin : g_bad_mult
      $error("wdg_interval: MULT_W must be positive");
   end

   logic [CNT_W-1:0] scaled [RES_CODES];

   // one shifted copy of the multiplier per resolution code
   for (genvar r = 0; r < RES_CODES; r++) begin : g_scale
      assign scaled[r] = CNT_W'(mult_i) << (2 * r);
   end

   assign ticks_o = scaled[res_i];
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdg_counter: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   // a reload in the same cycle wins over the final tick
   assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

   AST_CNT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q <= $past(cnt_q))); // R3
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> (cnt_q == '0 && !expire_o)); // R10
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int RES_W    = 2,
   parameter int MULT_W   = 5,
   parameter int FLAG_BIT = 7,
   parameter int CENT_BIT = 6,
   localparam int DATA_W  = RES_W + MULT_W + 1,
   localparam int STEER_BIT = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl_i,
   input  logic              wr_cent_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic [DATA_W-1:0] ctrl_o,
   output logic              flag_o,
   output logic              cent_o,
   output logic              rst_req_o,
   output logic              irq_o
);
   if (FLAG_BIT >= DATA_W || CENT_BIT >= DATA_W) begin : g_bad_bits
      $error("wdg_regs: bit position beyond data width");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              flag_q, cent_q, rst_q, irq_q;
   wdg_act_e          act;

   always_comb begin
      act = ACT_NONE;
      if (expire_i)
         act = ctrl_q[STEER_BIT] ? ACT_RST : ACT_IRQ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
         cent_q <= 1'b0;
         rst_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         rst_q <= (act == ACT_RST);
         irq_q <= (act == ACT_IRQ);
         if (wr_ctrl_i)
            ctrl_q <= wdata_i;
         else if (act == ACT_RST)
            ctrl_q <= '0;
         if (wr_ctrl_i)
            flag_q <= 1'b0;
         else if (act != ACT_NONE)
            flag_q <= 1'b1;
         if (wr_cent_i)
            cent_q <= wdata_i[CENT_BIT];
         else if (act == ACT_RST)
            cent_q <= 1'b0;
      end
   end

   assign ctrl_o    = ctrl_q;
   assign flag_o    = flag_q;
   assign cent_o    = cent_q;
   assign rst_req_o = rst_q;
   assign irq_o     = irq_q;

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_q && irq_q)); // R7
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q); // R7
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q); // R8
   AST_RST_WIPES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> (ctrl_q == '0 && !cent_q)); // R7
   AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q || irq_q) |-> flag_q); // R6
endmodule

// File: rtl/wdg_steer.sv
module wdg_steer #(
   parameter int               ADDR_W    = 13,
   parameter int               RES_W     = wdg_pkg::WDG_RES_W_DEF,
   parameter int               MULT_W    = wdg_pkg::WDG_MULT_W_DEF,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF7,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
   parameter logic [ADDR_W-1:0] CENT_ADDR = 13'h1FFC,
   parameter int               FLAG_BIT  = 7,
   parameter int               CENT_BIT  = 6,
   localparam int DATA_W    = RES_W + MULT_W + 1,
   localparam int RES_CODES = 2 ** RES_W,
   localparam int CNT_W     = MULT_W + 2 * (RES_CODES - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              wdg_rst_req_o,
   output logic              wdg_irq_o
);
   if (CTRL_ADDR == FLAG_ADDR || CTRL_ADDR == CENT_ADDR || FLAG_ADDR == CENT_ADDR) begin : g_bad_map
      $error("wdg_steer: register addresses overlap");
   end

   logic              wr_ctrl, wr_cent, rd_ctrl, load, expire;
   logic              flag, cent;
   logic [DATA_W-1:0] ctrl, load_src;
   logic [CNT_W-1:0]  load_ticks;

   assign wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);
   assign wr_cent = wr_en_i && (addr_i == CENT_ADDR);
   assign rd_ctrl = rd_en_i && (addr_i == CTRL_ADDR);
   assign load    = wr_ctrl || rd_ctrl;
   // a write brings its own value, a read reuses the stored one
   assign load_src = wr_ctrl ? wdata_i : ctrl;

   wdg_interval #(.RES_W(RES_W), .MULT_W(MULT_W)) u_interval (
      .res_i   (load_src[RES_W-1:0]),
      .mult_i  (load_src[RES_W+MULT_W-1:RES_W]),
      .ticks_o (load_ticks)
   );

   wdg_counter #(.CNT_W(CNT_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (load),
      .load_val_i (load_ticks),
      .expire_o   (expire)
   );

   wdg_regs #(.RES_W(RES_W), .MULT_W(MULT_W), .FLAG_BIT(FLAG_BIT), .CENT_BIT(CENT_BIT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl_i (wr_ctrl),
      .wr_cent_i (wr_cent),
      .wdata_i   (wdata_i),
      .expire_i  (expire),
      .ctrl_o    (ctrl),
      .flag_o    (flag),
      .cent_o    (cent),
      .rst_req_o (wdg_rst_req_o),
      .irq_o     (wdg_irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (addr_i == CTRL_ADDR)
            rdata_o = ctrl;
         else if (addr_i == FLAG_ADDR)
            rdata_o[FLAG_BIT] = flag;
         else if (addr_i == CENT_ADDR)
            rdata_o[CENT_BIT] = cent;
      end
   end

   AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == FLAG_ADDR && !expire) |=> (flag == $past(flag))); // R11
   AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !flag); // R4
endmodule

// File: tb/wdg_steer_tb_top.sv
module wdg_steer_tb_top;
   localparam logic [12:0] A_CTRL = 13'h1FF7;
   localparam logic [12:0] A_FLAG = 13'h1FF0;
   localparam logic [12:0] A_CENT = 13'h1FFC;
   localparam int NVEC = 6;
   // control byte, expected ticks to expiry (multiplier x 4^resolution)
   localparam logic [7:0] VEC_CTRL [NVEC] = '{8'h04, 8'h0D, 8'h8A, 8'h07, 8'h7C, 8'hFF};
   localparam int         VEC_TICKS[NVEC] = '{1, 12, 32, 64, 31, 1984};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rst_req, irq;
   int checks = 0, errors = 0;
   int irq_seen = 0, rst_seen = 0;

   always #2.5 clk = ~clk;

   wdg_steer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .wdg_rst_req_o(rst_req), .wdg_irq_o(irq)
   );

   always @(negedge clk) begin
      if (irq) irq_seen++;
      if (rst_req) rst_seen++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [12:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int i0, r0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 rst_req", int'(rst_req), 0);
      chk("R1 irq", int'(irq), 0);
      do_read(A_FLAG, d); chk("R1 flag", d, 8'h00);
      do_read(A_CENT, d); chk("R1 cent", d, 8'h00);
      do_read(A_CTRL, d); chk("R1 ctrl", d, 8'h00);

      // table walk: R2 R3 R4 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         do_write(A_CENT, 8'h40);
         do_write(A_CTRL, VEC_CTRL[v]);
         do_read(A_FLAG, d); chk("R4 flag cleared by write", d, 8'h00);
         i0 = irq_seen; r0 = rst_seen;
         ticks(VEC_TICKS[v] - 1);
         idle(1);
         chk("R3 no early irq", irq_seen, i0);
         chk("R3 no early rst", rst_seen, r0);
         ticks(1);
         idle(2);
         if (VEC_CTRL[v][7]) begin
            chk("R7 one rst pulse", rst_seen, r0 + 1);
            chk("R7 no irq", irq_seen, i0);
            do_read(A_CTRL, d); chk("R7 ctrl wiped", d, 8'h00);
            do_read(A_CENT, d); chk("R7 cent cleared", d, 8'h00);
         end else begin
            chk("R8 one irq pulse", irq_seen, i0 + 1);
            chk("R8 no rst", rst_seen, r0);
            do_read(A_CENT, d); chk("R8 cent kept", d, 8'h40);
            do_read(A_CTRL, d); chk("R2 ctrl readback", d, VEC_CTRL[v]);
         end
         do_read(A_FLAG, d); chk("R6 flag set", d, 8'h80);
      end

      // R10: after reset-steered expiry a read reloads zero, nothing fires
      i0 = irq_seen; r0 = rst_seen;
      ticks(50); idle(1);
      chk("R10 idle after steered expiry", irq_seen + rst_seen, i0 + r0);

      // R10: one-shot after interrupt expiry
      do_write(A_CTRL, 8'h08);   // mult 2, res 0 -> 2 ticks
      ticks(2); idle(2);
      chk("R8 irq for 0x08", irq_seen, i0 + 1);
      ticks(20); idle(1);
      chk("R10 no second irq", irq_seen, i0 + 1);

      // R11: flags writes ignored (set and clear cases)
      do_write(A_FLAG, 8'h00);
      do_read(A_FLAG, d); chk("R11 flag survives write", d, 8'h80);
      do_write(A_CTRL, 8'h00);
      do_write(A_FLAG, 8'hFF);
      do_read(A_FLAG, d); chk("R11 flag not set by write", d, 8'h00);

      // R12: only bit 6 of date register held
      do_write(A_CENT, 8'hFF);
      do_read(A_CENT, d); chk("R12 cent bit only", d, 8'h40);
      do_write(A_CENT, 8'hBF);
      do_read(A_CENT, d); chk("R12 cent cleared", d, 8'h00);

      // R9: zero multiplier disables
      i0 = irq_seen; r0 = rst_seen;
      do_write(A_CTRL, 8'h83);
      ticks(200); idle(1);
      chk("R9 no expiry with zero multiplier", irq_seen + rst_seen, i0 + r0);
      do_read(A_FLAG, d); chk("R9 flag stays clear", d, 8'h00);

      // R5: read of control byte restarts the countdown
      do_write(A_CTRL, 8'h0C);   // 3 ticks
      ticks(2);
      do_read(A_CTRL, d); chk("R5 read value", d, 8'h0C);
      ticks(2); idle(1);
      chk("R5 no expiry after read reload", irq_seen, i0);
      ticks(1); idle(2);
      chk("R5 expiry after full reload", irq_seen, i0 + 1);

      // R4: rewrite before expiry restarts
      do_write(A_CTRL, 8'h0C);
      ticks(2);
      do_write(A_CTRL, 8'h0C);
      ticks(2); idle(1);
      chk("R4 rewrite restarts", irq_seen, i0 + 1);
      ticks(1); idle(2);
      chk("R4 expiry after rewrite", irq_seen, i0 + 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule